// File: doc/BRIEF.md
# ADC Clock Prescaler and Result Formatter

This block holds the configuration byte that sets up a successive-approximation converter. The byte selects the source of the converter clock, sets a power-of-two division ratio and chooses how a 10-bit conversion value is laid out across two data bytes. The source is either the bus clock or the oscillator clock. The block does not produce a second clock. It drives `convEn`, a one-cycle enable pulse synchronous to `clk`, and the converter sequencer uses that pulse as its clock enable. The oscillator arrives as `oscTick`, a strobe that is already synchronous to `clk` and is high for one cycle per oscillator period.

Software writes and reads the configuration byte over a byte-wide register port. Address 0 holds the configuration. Addresses 1 and 2 return the formatted high and low result bytes, and address 3 reads as zero. Reads are combinational from `addr`. The formatted bytes also appear directly on `resHi` and `resLo`.

The converter clock must land near 1 MHz for correct conversions. Choosing a source and ratio that meet this is left to the integrator.

Top module: `adcClkFmtTop`

## Requirements
- R1: After reset the configuration byte reads 0x04: divider code 000, oscillator source, right-justified mode. With that setting `convEn` equals `oscTick` on every cycle.
- R2: In the configuration byte, bits 7:5 are the divider code, bit 4 is the source select and bits 3:2 are the format mode. Bits 1:0 always read 0, and writing them has no effect.
- R3: Divider codes 000, 001, 010 and 011 produce one `convEn` pulse per 1, 2, 4 and 8 source ticks respectively.
- R4: Any divider code with bit 7 of the configuration byte set (codes 100 to 111) produces one pulse per 16 source ticks, whatever its lower two bits are.
- R5: When the source select is 1, every `clk` cycle is a source tick. When it is 0, only cycles with `oscTick` high are source ticks. `convEn` is never high on a cycle that is not a source tick.
- R6: Every write to the configuration byte restarts the divide count. On the cycle after the write `convEn` is 0. The first pulse then comes on the Nth source tick after that cycle, where N is the division ratio.
- R7: Mode 00 (truncation): `resHi` = 0 and `resLo` = raw[9:2].
- R8: Mode 01 (right-justified): `resHi` = {000000, raw[9:8]} and `resLo` = raw[7:0].
- R9: Mode 10 (left-justified): `resHi` = raw[9:2] and `resLo` = {raw[1:0], 000000}.
- R10: Mode 11 (signed left-justified): same as R9, except that bit 7 of `resHi` is the inverse of raw[9].
- R11: Reads at address 1 return `resHi`, reads at address 2 return `resLo`, and reads at address 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data, combinational from `addr` |
| oscTick | input | 1 | One-cycle strobe per oscillator period, synchronous to `clk` |
| rawResult | input | 10 | Raw conversion value |
| convEn | output | 1 | Converter clock enable pulse |
| resHi | output | 8 | Formatted high result byte |
| resLo | output | 8 | Formatted low result byte |

## Verification
The bench checks the four clamped divider codes one by one. A design that decoded only the low two bits would pulse every 1 to 8 ticks instead of every 16. Every divider run begins with a register write in the middle of a count, so a design that kept its old count would emit a short first period or a pulse in the restart cycle. In runs on the oscillator source the strobe is sparse, which exposes a counter that advances on bus cycles. The format tests use all-ones, all-zeros, mid-scale and alternating raw values. These would show a dropped sign inversion, zeros placed at the wrong end of a byte, and reserved bits that retained written ones.

// File: rtl/adcFmtPkg.sv
`timescale 1ns/1ps
package adcFmtPkg;
  localparam int RAW_W  = 10;
  localparam int BYTE_W = 8;
  localparam int DIV_W  = 3;
  localparam int CNT_W  = 4;   // log2 of the largest ratio
  localparam int PAD_W  = 2 * BYTE_W - RAW_W;
  localparam int EXTRA_W = RAW_W - BYTE_W;

  typedef enum logic [1:0] {
    MODE_TRUNC  = 2'b00,
    MODE_RIGHT  = 2'b01,
    MODE_LEFT   = 2'b10,
    MODE_SIGNED = 2'b11
  } fmtModeT;

  typedef struct packed {
    logic [DIV_W-1:0] divCode;
    logic             busSel;
    fmtModeT          mode;
    logic             restart;
  } cfgT;
endpackage

// File: rtl/adcCfgCtrl.sv
`timescale 1ns/1ps
module adcCfgCtrl
  import adcFmtPkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int CFG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  output cfgT               cfg,
  output logic [BYTE_W-1:0] cfgByte
);
  logic [DIV_W-1:0] divQ;
  logic             busQ;
  fmtModeT          modeQ;
  logic             restartQ;
  logic             cfgWr;

  assign cfgWr = wrEn && (addr == ADDR_W'(CFG_ADDR));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divQ     <= '0;
      busQ     <= 1'b0;
      modeQ    <= MODE_RIGHT;
      restartQ <= 1'b0;
    end else begin
      restartQ <= cfgWr;
      if (cfgWr) begin
        divQ  <= wrData[7:5];
        busQ  <= wrData[4];
        modeQ <= fmtModeT'(wrData[3:2]);
      end
    end
  end

  assign cfg.divCode = divQ;
  assign cfg.busSel  = busQ;
  assign cfg.mode    = modeQ;
  assign cfg.restart = restartQ;
  assign cfgByte     = {divQ, busQ, modeQ, 2'b00};

  // R2: without a write the stored byte holds
  a_r2_cfg_holds: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWr |=> $stable(cfgByte));
  // R2: reserved bits never read back as one
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    cfgByte[1:0] == 2'b00);
endmodule

// File: rtl/adcClkFmt.sv
`timescale 1ns/1ps
module adcClkFmt
  import adcFmtPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cfgT               cfg,
  input  logic              oscTick,
  input  logic [RAW_W-1:0]  rawResult,
  output logic              convEn,
  output logic [BYTE_W-1:0] resHi,
  output logic [BYTE_W-1:0] resLo
);
  // ---------------- prescaler ----------------
  logic [2:0]     divShift;
  logic [CNT_W:0] ratio;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cntQ;
  logic           srcTick;
  logic           atLimit;

  assign divShift = cfg.divCode[DIV_W-1] ? 3'(CNT_W) : {1'b0, cfg.divCode[1:0]};
  assign ratio    = (CNT_W+1)'(1) << divShift;
  assign limit    = CNT_W'(ratio - (CNT_W+1)'(1));
  assign srcTick  = cfg.busSel | oscTick;
  assign atLimit  = (cntQ == limit);
  assign convEn   = srcTick & atLimit & ~cfg.restart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (cfg.restart) begin
      cntQ <= '0;
    end else if (srcTick) begin
      cntQ <= atLimit ? '0 : cntQ + CNT_W'(1);
    end
  end

  // ---------------- formatter ----------------
  always_comb begin
    resHi = '0;
    resLo = '0;
    unique case (cfg.mode)
      MODE_TRUNC: begin
        resLo = rawResult[RAW_W-1 -: BYTE_W];
      end
      MODE_RIGHT: begin
        resHi = {{PAD_W{1'b0}}, rawResult[RAW_W-1:BYTE_W]};
        resLo = rawResult[BYTE_W-1:0];
      end
      MODE_LEFT: begin
        resHi = rawResult[RAW_W-1 -: BYTE_W];
        resLo = {rawResult[EXTRA_W-1:0], {PAD_W{1'b0}}};
      end
      default: begin
        resHi = {~rawResult[RAW_W-1], rawResult[RAW_W-2 -: BYTE_W-1]};
        resLo = {rawResult[EXTRA_W-1:0], {PAD_W{1'b0}}};
      end
    endcase
  end

  // R5: no pulse without a source tick
  a_r5_tick_only: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.busSel && !oscTick) |-> !convEn);
  // R3: ratios above one never give back-to-back pulses
  a_r3_no_double: assert property (@(posedge clk) disable iff (!rstN)
    (convEn && cfg.divCode != 3'b000 && !cfg.restart) |=> !convEn);
  // R6: the cycle after a restart cannot pulse when the ratio exceeds one
  a_r6_restart_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.restart && cfg.divCode != 3'b000) |=> !convEn);
  // R8: right-justified upper bits are zero
  a_r8_right_pad: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.mode == MODE_RIGHT) |-> resHi[7:2] == 6'b0);
  // R9: left-justified lower bits are zero
  a_r9_left_pad: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.mode == MODE_LEFT) |-> resLo[5:0] == 6'b0);
  // R10: signed mode flips the sign bit
  a_r10_sign_flip: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.mode == MODE_SIGNED) |-> resHi[7] != rawResult[RAW_W-1]);
endmodule

// File: rtl/adcClkFmtTop.sv
`timescale 1ns/1ps
module adcClkFmtTop
  import adcFmtPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       oscTick,
  input  logic [9:0] rawResult,
  output logic       convEn,
  output logic [7:0] resHi,
  output logic [7:0] resLo
);
  cfgT        cfg;
  logic [7:0] cfgByte;

  adcCfgCtrl #(.ADDR_W(2), .CFG_ADDR(0)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .cfg(cfg), .cfgByte(cfgByte)
  );

  adcClkFmt u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .oscTick(oscTick),
    .rawResult(rawResult), .convEn(convEn), .resHi(resHi), .resLo(resLo)
  );

  always_comb begin
    unique case (addr)
      2'd0:    rdData = cfgByte;
      2'd1:    rdData = resHi;
      2'd2:    rdData = resLo;
      default: rdData = '0;
    endcase
  end

  // R11: the unused address reads zero
  a_r11_hole_zero: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 2'd3) |-> rdData == 8'h00);
  // R2: the configuration read never shows reserved ones
  a_r2_read_reserved: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 2'd0) |-> rdData[1:0] == 2'b00);
endmodule

// File: tb/adcClkFmtTop_bench.sv
`timescale 1ns/1ps
module adcClkFmtTop_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       oscTick = 1'b0;
  logic [9:0] rawResult = 10'h000;
  logic       convEn;
  logic [7:0] resHi, resLo;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  adcClkFmtTop u_adcClkFmtTop (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .oscTick(oscTick), .rawResult(rawResult),
    .convEn(convEn), .resHi(resHi), .resLo(resLo)
  );

  initial forever #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // returns at the falling edge of the cycle after the write
  task automatic writeReg(input logic [7:0] val);
    @(negedge clk);
    wrEn = 1'b1; addr = 2'd0; wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    addr = a;
    #1;
    check(rdData === exp, req, {8'h00, rdData}, {8'h00, exp});
  endtask

  task automatic testReset();
    readReg(2'd0, 8'h04, "R1 reset byte");
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      oscTick = (i % 3 != 0);
      #1;
      check(convEn === oscTick, "R1 div1 follows oscTick", {15'h0, convEn}, {15'h0, oscTick});
    end
    oscTick = 1'b0;
  endtask

  task automatic testLayout();
    writeReg(8'hFF);
    readReg(2'd0, 8'hFC, "R2 reserved bits ignore writes");
    writeReg(8'h4B);
    readReg(2'd0, 8'h48, "R2 field placement");
    writeReg(8'h04);
    readReg(2'd0, 8'h04, "R2 restore");
  endtask

  task automatic runDiv(input logic [2:0] code, input logic bus, input int ratio,
                        input string req);
    int ticks = 0;
    logic expEn;
    oscTick = 1'b0;
    writeReg({code, bus, 2'b01, 2'b00});
    for (int i = 0; i < 3 * ratio * 3 + 4; i++) begin
      oscTick = (i % 3 == 1);
      #1;
      if (i == 0) begin
        expEn = 1'b0;
        check(convEn === 1'b0, "R6 quiet after write", {15'h0, convEn}, 16'h0);
      end else begin
        if (bus || oscTick) begin
          ticks++;
          expEn = (ticks % ratio == 0);
        end else begin
          expEn = 1'b0;
        end
        check(convEn === expEn, req, {15'h0, convEn}, {15'h0, expEn});
      end
      @(negedge clk);
    end
    oscTick = 1'b0;
  endtask

  task automatic runFmt(input logic [1:0] mode, input logic [9:0] raw, input string req);
    logic [7:0] eh, el;
    case (mode)
      2'b00: begin eh = 8'h00; el = raw[9:2]; end
      2'b01: begin eh = {6'b0, raw[9:8]}; el = raw[7:0]; end
      2'b10: begin eh = raw[9:2]; el = {raw[1:0], 6'b0}; end
      default: begin eh = {~raw[9], raw[8:2]}; el = {raw[1:0], 6'b0}; end
    endcase
    writeReg({3'b000, 1'b1, mode, 2'b00});
    rawResult = raw;
    #1;
    check(resHi === eh, {req, " high"}, {8'h0, resHi}, {8'h0, eh});
    check(resLo === el, {req, " low"}, {8'h0, resLo}, {8'h0, el});
    readReg(2'd1, eh, "R11 read high");
    readReg(2'd2, el, "R11 read low");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testLayout();
    runDiv(3'b000, 1'b1, 1, "R3 div1 bus");
    runDiv(3'b001, 1'b1, 2, "R3 div2 bus");
    runDiv(3'b010, 1'b1, 4, "R3 div4 bus");
    runDiv(3'b011, 1'b1, 8, "R3 div8 bus");
    runDiv(3'b100, 1'b1, 16, "R4 code100 bus");
    runDiv(3'b101, 1'b1, 16, "R4 code101 bus");
    runDiv(3'b110, 1'b0, 16, "R4 code110 osc");
    runDiv(3'b111, 1'b1, 16, "R4 code111 bus");
    runDiv(3'b001, 1'b0, 2, "R5 div2 osc");
    runDiv(3'b010, 1'b0, 4, "R5 div4 osc");
    runDiv(3'b011, 1'b1, 8, "R6 restart mid count");
    foreach (rawVals[k]) begin
      runFmt(2'b00, rawVals[k], "R7 trunc");
      runFmt(2'b01, rawVals[k], "R8 right");
      runFmt(2'b10, rawVals[k], "R9 left");
      runFmt(2'b11, rawVals[k], "R10 signed");
    end
    readReg(2'd3, 8'h00, "R11 hole address");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [9:0] rawVals [5] = '{10'h3FF, 10'h000, 10'h200, 10'h2A5, 10'h15A};
endmodule